// File: doc/BRIEF.md
# Hardwired Step Sequencer for an Accumulator Datapath

This block is the hardwired control unit of a small accumulator machine. It works through one register-transfer line per clock. A one-hot step register holds the current timing step, T0 to T7. Combinational logic crosses the active step with the 4-bit opcode of the instruction being executed. That logic produces two things: a 6-bit bus-select word, made of a 3-bit source unit address and a 3-bit destination unit address, and a 4-bit one-hot ALU command. When the final line of an instruction has been issued, the block raises a step-clear strobe, and the step register returns to T0 on the following clock.

The instruction register drives the opcode input. It holds the opcode steady for the whole instruction, and the datapath consumes the control outputs in the same cycle that the step is active. The block recognises two opcodes. Code 3 adds the memory operand to the accumulator. Code 4 subtracts it. Both take four steps. Any other code is retired at once by the step-clear strobe, so the sequencer can never stall.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `t_step` becomes 8'b0000_0001 (step T0) after that edge.
- R2: Outside reset, exactly one bit of `t_step` is high in every cycle.
- R3: When `cnt_clr` is low, each clock moves the active step up by one bit position, and bit 7 wraps to bit 0.
- R4: When `cnt_clr` is high, the next clock returns `t_step` to T0, whatever the current step is.
- R5: For opcode 3 at T0, `bus_ctl` is 6'b001_111. Bits [2:0] hold the source address (7, the instruction register) and bits [5:3] hold the destination address (1, the memory address register). `alu_ctl` is 0 and `cnt_clr` is 0.
- R6: For opcode 3 at T1, `bus_ctl` is 6'b011_000 (source 0 is memory, destination 3 is the memory buffer register). `alu_ctl` is 0 and `cnt_clr` is 0.
- R7: For opcode 3 at T2, `alu_ctl` is 4'b0001 (bit 0 is add) and `bus_ctl` is 0.
- R8: For opcode 3 at T3, `cnt_clr` is 1, and both `bus_ctl` and `alu_ctl` are 0.
- R9: Opcode 4 produces the same outputs as opcode 3 in every step, except at T2, where `alu_ctl` is 4'b0010 (bit 1 is subtract).
- R10: For any opcode other than 3 or 4, `cnt_clr` is 1 and `bus_ctl` and `alu_ctl` are 0 in the current step, so the instruction ends after that cycle.
- R11: `alu_ctl` never has more than one bit set, and bit 3 (no operation) is never driven high.
- R12: Reset is synchronous and active high. It overrides step advance, so a reset in the middle of an instruction puts the sequencer in T0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Opcode of the instruction being executed |
| t_step | output | 8 | One-hot timing step, bit k is Tk |
| bus_ctl | output | 6 | Bus select: [2:0] source address, [5:3] destination address |
| alu_ctl | output | 4 | One-hot ALU command: bit 0 add, bit 1 subtract |
| cnt_clr | output | 1 | Step-clear strobe, returns the step to T0 on the next clock |

## Verification
Two things can try to move the step register at the same clock edge: the step-clear strobe at the end of an instruction and the synchronous reset. Both send it to T0, so they can also coincide with normal advance. The bench raises reset in T1 of an add, where the step would otherwise advance. It also raises reset exactly in T3, where the clear strobe is already high. In both cases it checks that the next step is T0, and that normal advance to T1 resumes once reset is released. It also swaps in an unsupported opcode mid-instruction and checks that the clear strobe appears in that same cycle.

// File: rtl/ctl_seq_pkg.sv
`timescale 1ns/1ps
package ctl_seq_pkg;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned ALU_W = 4;
  localparam int unsigned BUS_W = 2 * SEL_W;

  // opcodes recognised by the decode map
  localparam logic [OP_W-1:0] OP_ADD  = 4'd3;
  localparam logic [OP_W-1:0] OP_SUBT = 4'd4;

  // unit addresses on the shared bus
  localparam logic [SEL_W-1:0] UNIT_MEM   = 3'd0;
  localparam logic [SEL_W-1:0] UNIT_MADDR = 3'd1;
  localparam logic [SEL_W-1:0] UNIT_MBUF  = 3'd3;
  localparam logic [SEL_W-1:0] UNIT_INSTR = 3'd7;

  // bit positions in the one-hot ALU command
  localparam int unsigned ALU_BIT_ADD = 0;
  localparam int unsigned ALU_BIT_SUB = 1;

  typedef struct packed {
    logic [SEL_W-1:0] dst;
    logic [SEL_W-1:0] src;
  } bus_word_t;
endpackage

// File: rtl/seq_step_ring.sv
`timescale 1ns/1ps
module seq_step_ring #(
  parameter int unsigned STEPS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [STEPS-1:0] step
);
  logic [STEPS-1:0] step_nxt;

  // one-hot ring: clear forces bit 0, otherwise rotate left
  genvar gi;
  generate
    for (gi = 0; gi < STEPS; gi++) begin : g_bit
      if (gi == 0) begin : g_first
        assign step_nxt[gi] = clr | step[STEPS-1];
      end else begin : g_rest
        assign step_nxt[gi] = ~clr & step[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= {{(STEPS-1){1'b0}}, 1'b1};
    end else begin
      step <= step_nxt;
    end
  end
endmodule

// File: rtl/seq_step_decode.sv
`timescale 1ns/1ps
module seq_step_decode
  import ctl_seq_pkg::*;
#(
  parameter int unsigned STEPS = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [STEPS-1:0] step,
  output logic [BUS_W-1:0] bus_sel,
  output logic [ALU_W-1:0] alu_sel,
  output logic             clr
);
  localparam int unsigned USED_STEPS = 4;

  bus_word_t bw;
  logic      late_step;

  assign late_step = |step[STEPS-1:USED_STEPS];

  always_comb begin
    bw      = '0;
    alu_sel = '0;
    clr     = 1'b0;
    unique case (op)
      OP_ADD, OP_SUBT: begin
        if (step[0]) begin
          bw.src = UNIT_INSTR;
          bw.dst = UNIT_MADDR;
        end
        if (step[1]) begin
          bw.src = UNIT_MEM;
          bw.dst = UNIT_MBUF;
        end
        if (step[2]) begin
          if (op == OP_SUBT) alu_sel[ALU_BIT_SUB] = 1'b1;
          else               alu_sel[ALU_BIT_ADD] = 1'b1;
        end
        // final step, or a step the map never reaches: retire
        if (step[3] || late_step) clr = 1'b1;
      end
      default: begin
        clr = 1'b1;
      end
    endcase
  end

  assign bus_sel = bw;
endmodule

// File: rtl/ctl_sequencer.sv
`timescale 1ns/1ps
module ctl_sequencer
  import ctl_seq_pkg::*;
#(
  parameter int unsigned STEPS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OP_W-1:0]      op_code,
  output logic [STEPS-1:0]     t_step,
  output logic [BUS_W-1:0]     bus_ctl,
  output logic [ALU_W-1:0]     alu_ctl,
  output logic                 cnt_clr
);
  logic [STEPS-1:0] step_q;
  logic             clr_c;

  seq_step_ring #(.STEPS(STEPS)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_c),
    .step (step_q)
  );

  seq_step_decode #(.STEPS(STEPS)) u_dec (
    .op      (op_code),
    .step    (step_q),
    .bus_sel (bus_ctl),
    .alu_sel (alu_ctl),
    .clr     (clr_c)
  );

  assign t_step  = step_q;
  assign cnt_clr = clr_c;
endmodule

// File: rtl/ctl_sequencer_chk.sv
`timescale 1ns/1ps
module ctl_sequencer_chk
  import ctl_seq_pkg::*;
#(
  parameter int unsigned STEPS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  op_code,
  input logic [STEPS-1:0] t_step,
  input logic [BUS_W-1:0] bus_ctl,
  input logic [ALU_W-1:0] alu_ctl,
  input logic             cnt_clr
);
  localparam logic [STEPS-1:0] FIRST = {{(STEPS-1){1'b0}}, 1'b1};

  // R1 / R12: reset lands on T0
  a_r1_reset_t0: assert property (@(posedge clk) rst |=> t_step == FIRST);

  // R2
  a_r2_one_step: assert property (@(posedge clk) disable iff (rst)
    $countones(t_step) == 1);

  // R3
  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !t_step[STEPS-1]) |=> t_step == ($past(t_step) << 1));

  // R4
  a_r4_clr_return: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> t_step == FIRST);

  // R7 / R9: arithmetic step issues the matching ALU command
  a_r7_add_cmd: assert property (@(posedge clk) disable iff (rst)
    (t_step[2] && op_code == OP_ADD) |-> alu_ctl == 4'b0001);
  a_r9_sub_cmd: assert property (@(posedge clk) disable iff (rst)
    (t_step[2] && op_code == OP_SUBT) |-> alu_ctl == 4'b0010);

  // R10
  a_r10_bad_op: assert property (@(posedge clk) disable iff (rst)
    (op_code != OP_ADD && op_code != OP_SUBT) |-> (cnt_clr && bus_ctl == '0 && alu_ctl == '0));

  // R11
  a_r11_alu_clean: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alu_ctl) && !alu_ctl[ALU_W-1]);
endmodule

bind ctl_sequencer ctl_sequencer_chk #(.STEPS(STEPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_code (op_code),
  .t_step  (t_step),
  .bus_ctl (bus_ctl),
  .alu_ctl (alu_ctl),
  .cnt_clr (cnt_clr)
);

// File: tb/tb_ctl_sequencer.sv
`timescale 1ns/1ps
module tb_ctl_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = 4'd0;
  logic [7:0] t_step;
  logic [5:0] bus_ctl;
  logic [3:0] alu_ctl;
  logic       cnt_clr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ctl_sequencer dut (
    .clk(clk), .rst(rst), .op_code(op_code),
    .t_step(t_step), .bus_ctl(bus_ctl), .alu_ctl(alu_ctl), .cnt_clr(cnt_clr)
  );

  // vector: {op[22:19], step[18:11], bus[10:5], alu[4:1], clr[0]}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {4'd3,  8'h01, 6'b001111, 4'b0000, 1'b0},  // R5
    {4'd3,  8'h02, 6'b011000, 4'b0000, 1'b0},  // R6
    {4'd3,  8'h04, 6'b000000, 4'b0001, 1'b0},  // R7
    {4'd3,  8'h08, 6'b000000, 4'b0000, 1'b1},  // R8
    {4'd4,  8'h01, 6'b001111, 4'b0000, 1'b0},  // R9
    {4'd4,  8'h02, 6'b011000, 4'b0000, 1'b0},  // R9
    {4'd4,  8'h04, 6'b000000, 4'b0010, 1'b0},  // R9
    {4'd4,  8'h08, 6'b000000, 4'b0000, 1'b1},  // R9
    {4'd0,  8'h01, 6'b000000, 4'b0000, 1'b1},  // R10
    {4'd9,  8'h01, 6'b000000, 4'b0000, 1'b1},  // R10
    {4'd3,  8'h01, 6'b001111, 4'b0000, 1'b0},  // R5
    {4'd3,  8'h02, 6'b011000, 4'b0000, 1'b0},  // R6
    {4'd3,  8'h04, 6'b000000, 4'b0001, 1'b0},  // R7
    {4'd3,  8'h08, 6'b000000, 4'b0000, 1'b1},  // R8
    {4'd15, 8'h01, 6'b000000, 4'b0000, 1'b1}   // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset step", {24'd0, t_step}, 32'h01);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      op_code = VEC[i][22:19];
      #1;
      chk("R3/R4 step", {24'd0, t_step}, {24'd0, VEC[i][18:11]});
      chk("R5-R10 bus", {26'd0, bus_ctl}, {26'd0, VEC[i][10:5]});
      chk("R7/R9 alu", {28'd0, alu_ctl}, {28'd0, VEC[i][4:1]});
      chk("R8/R10 clr", {31'd0, cnt_clr}, {31'd0, VEC[i][0]});
      chk("R11 alu bit3", {31'd0, alu_ctl[3]}, 32'd0);
      chk("R2 one step", $countones(t_step), 32'd1);
      @(negedge clk);
    end

    // R12: reset in T1 overrides advance
    op_code = 4'd3;
    @(negedge clk);
    chk("R3 to T1", {24'd0, t_step}, 32'h02);
    rst = 1'b1;
    @(negedge clk);
    chk("R12 mid reset", {24'd0, t_step}, 32'h01);
    chk("R5 after reset", {26'd0, bus_ctl}, 32'b001111);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R8 T3 clr", {31'd0, cnt_clr}, 32'd1);
    // reset coincides with the clear strobe
    rst = 1'b1;
    @(negedge clk);
    chk("R4 R12 together", {24'd0, t_step}, 32'h01);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 resumes", {24'd0, t_step}, 32'h02);
    // unsupported opcode mid-instruction
    op_code = 4'd9;
    #1;
    chk("R10 mid clr", {31'd0, cnt_clr}, 32'd1);
    chk("R10 mid bus", {26'd0, bus_ctl}, 32'd0);
    @(negedge clk);
    chk("R4 return T0", {24'd0, t_step}, 32'h01);
    finish_run();
  end
endmodule